// File: doc/BRIEF.md
# Direct-Mapped Cache with Miss-Cause Classifier

This block is a small direct-mapped cache that sits between a requester and a slower backing memory. Each line stores a valid flag, a tag and one data block. A request is accepted when the block is idle. The block looks up the indexed line. On a hit it answers at once. On a miss it holds the requester stalled, reads the whole block from backing memory, installs it, and then answers. Every answer reports whether the access hit. If it missed, the answer also gives the cause.

The cause of a miss is found with two extra structures. A one-bit-per-block map records every block that has been touched since reset. A miss on an untouched block is a first-touch (compulsory) miss. For the other misses, a shadow fully associative store with as many entries as the cache has lines, kept in least-recently-used order, is consulted. If the block is still present in that store, the real cache lost it only because two blocks share an index, so the miss is a conflict miss. If the block is absent, too many distinct blocks came in between, so the miss is a capacity miss.

Four saturating counters total the hits and the three miss causes. They are visible as outputs.

Top module: `dmcache_top`

## Requirements
- R1: The address is split, from low to high bits, into OFF_W byte-select bits, IDX_W line-index bits and a tag made of the remaining bits. An access hits only when the indexed line is valid and its stored tag equals the address tag.
- R2: After reset every line is invalid, the seen-block map and the shadow store are empty, all four counters read zero, and stall, memReq and rspReady are low.
- R3: On a miss, memReq rises and stays high until memAck. memAddr carries the block address (the address without its byte-select bits), and stall stays high until the response. rspData is then the byte returned by backing memory.
- R4: After a fill, the filled line is valid with the new tag, so an immediate repeat of the same address hits and returns the same data.
- R5: A miss on a block never accessed since reset is reported as compulsory (rspKind = 1), whatever the indexed line holds.
- R6: A miss on a previously accessed block that is still held in the shadow LRU store is reported as conflict (rspKind = 3).
- R7: A miss on a previously accessed block that has aged out of the shadow LRU store is reported as capacity (rspKind = 2).
- R8: A hit in the real cache is reported as a hit (rspKind = 0) even when the shadow store no longer holds the block.
- R9: Each completed access adds one to exactly one of the counters cntHit, cntCold, cntCap and cntConf, chosen by its rspKind. Each counter stops at its maximum value, 2^CNT_W-1.
- R10: A reqValid asserted while stall is high is ignored. It produces no response, no counter change and no entry in the seen-block map.
- R11: rspReady is a one-cycle pulse. For a hit it is high in the second cycle after the clock edge that accepts the request.
- R12: After reset, the block addresses 1, 6, 1, 26, 6 give, in order: compulsory, compulsory, hit, compulsory, conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only while stall is low |
| reqAddr | input | ADDR_W | Byte address of the request |
| stall | output | 1 | High from acceptance until the response cycle ends |
| rspReady | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Addressed byte, valid with rspReady |
| rspKind | output | 2 | 0 hit, 1 compulsory, 2 capacity, 3 conflict; valid with rspReady |
| memReq | output | 1 | Backing-memory block read request, held until memAck |
| memAddr | output | ADDR_W-OFF_W | Block address of the read |
| memAck | input | 1 | One-cycle acknowledge carrying memData |
| memData | input | 8*2^OFF_W | Block data from backing memory |
| cntHit | output | CNT_W | Saturating hit count |
| cntCold | output | CNT_W | Saturating compulsory-miss count |
| cntCap | output | CNT_W | Saturating capacity-miss count |
| cntConf | output | CNT_W | Saturating conflict-miss count |

## Verification
Some rules can be checked by assertions on every cycle. These are: the response is a single-cycle pulse; a fill makes the very next lookup hit; a block read is only outstanding while the indexed line misses; stall never drops before the response; and a full counter never moves. The bench scenarios are needed to show the miss-cause sorting, because it depends on the history of accesses. These scenarios cover the worked five-access sequence, a capacity eviction after five distinct blocks, a direct hit on a block the shadow store has dropped, and a request pulsed during a fill that later still counts as a first touch.

// File: rtl/dmcache_pkg.sv
package dmcache_pkg;
  typedef enum logic [1:0] {
    KIND_HIT  = 2'd0,
    KIND_COLD = 2'd1,
    KIND_CAP  = 2'd2,
    KIND_CONF = 2'd3
  } missKind_t;

  typedef struct packed {
    logic latchAddr;
    logic classify;
    logic fillWrite;
    logic commit;
  } ctrlStrobe_t;
endpackage

// File: rtl/dmcache_datapath.sv
module dmcache_datapath
  import dmcache_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 0,
  parameter int CNT_W  = 8,
  localparam int BLKA_W = ADDR_W - OFF_W,
  localparam int BLK_W  = 8 << OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BLK_W-1:0]  memData,
  output logic              lookupHit,
  output logic [BLKA_W-1:0] memAddr,
  output logic [7:0]        rspData,
  output logic [1:0]        rspKind,
  output logic [CNT_W-1:0]  cntHit,
  output logic [CNT_W-1:0]  cntCold,
  output logic [CNT_W-1:0]  cntCap,
  output logic [CNT_W-1:0]  cntConf
);
  localparam int TAG_W = BLKA_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam int NBLK  = 1 << BLKA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_W) - 1);

  logic [ADDR_W-1:0] addrQ;
  logic              lineValid [LINES];
  logic [TAG_W-1:0]  lineTag   [LINES];
  logic [BLK_W-1:0]  lineData  [LINES];
  logic [NBLK-1:0]   seenMap;
  logic              shValid   [LINES];
  logic [BLKA_W-1:0] shBlk     [LINES];
  missKind_t         kindQ, kindNow;

  logic [BLKA_W-1:0] blkAddr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [ADDR_W-1:0] byteSel;
  logic              shHit;
  logic [IDX_W-1:0]  shPos;

  assign blkAddr = addrQ[ADDR_W-1:OFF_W];
  assign idx     = blkAddr[IDX_W-1:0];
  assign tag     = blkAddr[BLKA_W-1:IDX_W];
  assign byteSel = addrQ & OFF_MASK;
  assign memAddr = blkAddr;
  assign lookupHit = lineValid[idx] && (lineTag[idx] == tag);
  assign rspData = lineData[idx][byteSel*8 +: 8];
  assign rspKind = kindQ;

  // Shadow store search; on a miss the whole list shifts (position = last)
  always_comb begin
    shHit = 1'b0;
    shPos = IDX_W'(LINES - 1);
    for (int i = 0; i < LINES; i++) begin
      if (shValid[i] && shBlk[i] == blkAddr) begin
        shHit = 1'b1;
        shPos = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (lookupHit)             kindNow = KIND_HIT;
    else if (!seenMap[blkAddr]) kindNow = KIND_COLD;
    else if (shHit)            kindNow = KIND_CONF;
    else                       kindNow = KIND_CAP;
  end

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      kindQ   <= KIND_HIT;
      seenMap <= '0;
      cntHit  <= '0;
      cntCold <= '0;
      cntCap  <= '0;
      cntConf <= '0;
      for (int i = 0; i < LINES; i++) begin
        lineValid[i] <= 1'b0;
        lineTag[i]   <= '0;
        lineData[i]  <= '0;
        shValid[i]   <= 1'b0;
        shBlk[i]     <= BLKA_W'(i);
      end
    end else begin
      if (strobe.latchAddr) addrQ <= reqAddr;
      if (strobe.classify)  kindQ <= kindNow;
      if (strobe.fillWrite) begin
        lineValid[idx] <= 1'b1;
        lineTag[idx]   <= tag;
        lineData[idx]  <= memData;
      end
      if (strobe.commit) begin
        seenMap[blkAddr] <= 1'b1;
        for (int i = 1; i < LINES; i++) begin
          if (i <= int'(shPos)) begin
            shBlk[i]   <= shBlk[i-1];
            shValid[i] <= shValid[i-1];
          end
        end
        shBlk[0]   <= blkAddr;
        shValid[0] <= 1'b1;
        case (kindQ)
          KIND_HIT:  cntHit  <= satInc(cntHit);
          KIND_COLD: cntCold <= satInc(cntCold);
          KIND_CAP:  cntCap  <= satInc(cntCap);
          default:   cntConf <= satInc(cntConf);
        endcase
      end
    end
  end

  // R4: the line just filled must satisfy the next lookup
  p_fill_then_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWrite |=> lookupHit);

  // R9: a counter at its ceiling stays there
  p_hit_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cntHit == CNT_MAX) |=> (cntHit == CNT_MAX));
  p_cold_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cntCold == CNT_MAX) |=> (cntCold == CNT_MAX));
endmodule

// File: rtl/dmcache_ctrl.sv
module dmcache_ctrl
  import dmcache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lookupHit,
  input  logic        memAck,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        rspReady,
  output logic        stall
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL, ST_RESP} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.latchAddr = 1'b1;
        stateNext = ST_LOOK;
      end
      ST_LOOK: begin
        strobe.classify = 1'b1;
        stateNext = lookupHit ? ST_RESP : ST_FILL;
      end
      ST_FILL: if (memAck) begin
        strobe.fillWrite = 1'b1;
        stateNext = ST_RESP;
      end
      default: begin
        strobe.commit = 1'b1;
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq   = (state == ST_FILL);
  assign rspReady = (state == ST_RESP);
  assign stall    = (state != ST_IDLE);

  // R11: completion is a single-cycle pulse
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> !rspReady);
  // R3: a block read is only outstanding while the line misses
  p_read_on_miss_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !lookupHit);
  // R10: stall holds until the response has been given
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !rspReady) |=> stall);
endmodule

// File: rtl/dmcache_top.sv
module dmcache_top
  import dmcache_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 0,
  parameter int CNT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic                      stall,
  output logic                      rspReady,
  output logic [7:0]                rspData,
  output logic [1:0]                rspKind,
  output logic                      memReq,
  output logic [ADDR_W-OFF_W-1:0]   memAddr,
  input  logic                      memAck,
  input  logic [(8<<OFF_W)-1:0]     memData,
  output logic [CNT_W-1:0]          cntHit,
  output logic [CNT_W-1:0]          cntCold,
  output logic [CNT_W-1:0]          cntCap,
  output logic [CNT_W-1:0]          cntConf
);
  ctrlStrobe_t strobe;
  logic        lookupHit;

  dmcache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lookupHit(lookupHit),
    .memAck(memAck), .strobe(strobe), .memReq(memReq),
    .rspReady(rspReady), .stall(stall)
  );

  dmcache_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .memData(memData), .lookupHit(lookupHit), .memAddr(memAddr),
    .rspData(rspData), .rspKind(rspKind), .cntHit(cntHit),
    .cntCold(cntCold), .cntCap(cntCap), .cntConf(cntConf)
  );
endmodule

// File: tb/dmcache_top_bench.sv
module dmcache_top_bench;
  localparam int MEM_LAT = 3;
  localparam int K_HIT = 0, K_COLD = 1, K_CAP = 2, K_CONF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [4:0] reqAddr = '0;
  logic stall, rspReady, memReq;
  logic [7:0] rspData;
  logic [1:0] rspKind;
  logic [4:0] memAddr;
  logic memAck = 1'b0;
  logic [7:0] memData = '0;
  logic [7:0] cntHit, cntCold, cntCap, cntConf;

  int nChecks = 0, nFails = 0, cycles = 0, lat = 0;
  int eHit = 0, eCold = 0, eCap = 0, eConf = 0;

  always #4 clk = ~clk;

  dmcache_top u_dmcache_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .stall(stall), .rspReady(rspReady), .rspData(rspData), .rspKind(rspKind),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .cntHit(cntHit), .cntCold(cntCold), .cntCap(cntCap), .cntConf(cntConf)
  );

  function automatic logic [7:0] memVal(input logic [4:0] blk);
    return 8'(int'(blk) * 29 + 5);
  endfunction

  // backing memory model with fixed latency
  always @(negedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
      lat <= 0;
    end else if (memReq) begin
      if (lat == MEM_LAT) begin
        memAck  <= 1'b1;
        memData <= memVal(memAddr);
      end else lat <= lat + 1;
    end else lat <= 0;
  end

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkCounters(input string req);
    eHit = (eHit > 255) ? 255 : eHit;
    chk(cntHit == 8'(eHit), req, cntHit, eHit);
    chk(cntCold == 8'(eCold), req, cntCold, eCold);
    chk(cntCap == 8'(eCap), req, cntCap, eCap);
    chk(cntConf == 8'(eConf), req, cntConf, eConf);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    eHit = 0; eCold = 0; eCap = 0; eConf = 0;
  endtask

  // one access; injectAddr >= 0 pulses a second request while stalled
  task automatic access(input int addr, input int expKind, input string req,
                        input int injectAddr = -1);
    int n;
    bit sawMem;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 5'(addr);
    @(negedge clk);
    reqValid = 1'b0;
    chk(stall == 1'b1, "R3 stall", stall, 1);
    if (injectAddr >= 0) begin
      reqValid = 1'b1; reqAddr = 5'(injectAddr);
      @(negedge clk);
      reqValid = 1'b0;
      n = 2;
    end else n = 1;
    sawMem = 1'b0;
    while (!rspReady && n < 100) begin
      if (memReq && !sawMem) begin
        sawMem = 1'b1;
        chk(memAddr == 5'(addr), "R3 memAddr", memAddr, addr);
      end
      if (!rspReady) chk(stall == 1'b1, "R3 stall held", stall, 1);
      @(negedge clk);
      n++;
    end
    chk(rspReady == 1'b1, {req, " response"}, rspReady, 1);
    chk(int'(rspKind) == expKind, {req, " kind"}, rspKind, expKind);
    chk(rspData == memVal(5'(addr)), {req, " data"}, rspData, memVal(5'(addr)));
    if (expKind == K_HIT) begin
      chk(n == 2, "R11 hit latency", n, 2);
      chk(!sawMem, "R1 no read on hit", sawMem, 0);
      eHit++;
    end else begin
      chk(sawMem, "R3 read on miss", sawMem, 1);
      if (expKind == K_COLD) eCold++;
      else if (expKind == K_CAP) eCap++;
      else eConf++;
    end
    @(negedge clk);
    chk(rspReady == 1'b0, "R11 pulse", rspReady, 0);
    chk(stall == 1'b0, "R3 stall released", stall, 0);
    chkCounters({req, " R9 counters"});
  endtask

  task automatic tReset();
    doReset();
    chk(stall == 1'b0, "R2 stall", stall, 0);
    chk(memReq == 1'b0, "R2 memReq", memReq, 0);
    chk(rspReady == 1'b0, "R2 rspReady", rspReady, 0);
    chkCounters("R2 counters");
  endtask

  task automatic tWorkedSequence();
    doReset();
    access(1, K_COLD, "R12 R5 first");
    access(6, K_COLD, "R12 R5 second");
    access(1, K_HIT, "R12 R1 R4 repeat");
    access(26, K_COLD, "R12 R5 other tag");
    access(6, K_CONF, "R12 R6 conflict");
    access(6, K_HIT, "R4 refill hit");
  endtask

  task automatic tCapacity();
    doReset();
    for (int b = 0; b < 5; b++) access(b, K_COLD, "R5 fill five");
    access(0, K_CAP, "R7 capacity");
    access(1, K_HIT, "R8 hit beats shadow");
    access(4, K_CONF, "R6 conflict after capacity");
  endtask

  task automatic tBusyIgnore();
    doReset();
    access(9, K_COLD, "R10 main miss", 17);
    repeat (5) begin
      @(negedge clk);
      chk(rspReady == 1'b0, "R10 no extra response", rspReady, 0);
    end
    chkCounters("R10 counters unchanged");
    access(17, K_COLD, "R10 ignored block still unseen");
  endtask

  task automatic tSaturate();
    doReset();
    access(3, K_COLD, "R9 warm");
    for (int i = 0; i < 260; i++) access(3, K_HIT, "R9 saturate");
    chk(cntHit == 8'd255, "R9 ceiling", cntHit, 255);
  endtask

  initial begin
    tReset();
    tWorkedSequence();
    tCapacity();
    tBusyIgnore();
    tSaturate();
    finishRun();
  end
endmodule